// File: doc/BRIEF.md
# Pre-trigger sequencing channel

This block is one channel of a conversion scheduler. A single start event (the detected edge of a trigger source, or a software trigger, delivered here as a one-cycle pulse) arms up to eight pre-trigger slots. Each enabled slot then issues one request to an analog converter. A slot fires in one of three ways: immediately, one cycle after the start; when a shared, externally kept counter equals the slot's own 16-bit delay; or chained, one cycle after the converter finishes the conversion launched by the slot just below it.

Requests are presented as a one-cycle pulse with a 3-bit index naming the slot. The channel follows the conversions it launches. If it issues a request while one of its own conversions is still running, the converter turns the request down and the channel records a sequence error for that slot. A per-slot flag records which delay matches occurred since the last start. The counter and the converter sit outside the block. The block is configured through a simple write port.

Top module: `pretrig_channel`

## Requirements
- R1: After reset, and while reset is held, `pt_fire_o` is 0, `err_o` is 0 and `flag_o` is 0. A slot armed before a reset does not fire after it.
- R2: An enabled slot in immediate mode (mode bit 0, no chaining) raises `pt_fire_o` in the cycle after `start_i` is high, with `pt_sel_o` equal to the slot number. Its delay value has no effect.
- R3: An enabled slot in delay mode (mode bit 1) fires once per start, in the cycle after the first cycle following the start in which `count_i` equals its delay. `flag_o` for that slot goes to 1 in the same cycle the pulse appears.
- R4: A slot whose enable bit is 0 never fires, whatever its mode bit.
- R5: A slot m of 1 or more with its chain bit set fires one cycle after `conv_done_i` ends a conversion launched by slot m-1, and its delay is ignored. The chain bit of slot 0 has no effect.
- R6: Each firing is a one-cycle pulse. Requests arising in the same cycle are issued one per cycle, lowest slot number first, and none are dropped.
- R7: A firing while `conv_busy_i` is high for a conversion this channel launched, and `conv_done_i` is low, sets `err_o` for the fired slot in the next cycle.
- R8: A write to the status address clears each error bit written 0 and keeps each error bit written 1.
- R9: A flag bit clears when written 0 at the status address, keeps its value when written 1, and all flags clear on a start.
- R10: When an error bit is set and written 0 in the same cycle, the set wins.
- R11: Write map: address 0 takes `{chain[23:16], mode[15:8], enable[7:0]}`. Address 1 takes `{flag[23:16], error[7:0]}`. Address 2+m takes the delay of slot m in bits [15:0]. Every write takes effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start event pulse |
| count_i | input | 16 | Shared delay counter value |
| conv_busy_i | input | 1 | Converter busy |
| conv_done_i | input | 1 | Converter conversion-complete pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 24 | Register write data |
| pt_fire_o | output | 1 | Pre-trigger pulse |
| pt_sel_o | output | 3 | Index of the slot that fired |
| err_o | output | 8 | Sequence error bits, one per slot |
| flag_o | output | 8 | Delay-match flags, one per slot |

## Verification
Two things can land on an error bit in the same clock: the hardware marking it because a request was turned down, and software clearing it through a status write. The bench enables slots 2 and 5 in immediate mode, so that slot 5 is issued one cycle after slot 2 and meets a busy converter. It drives a status write of all zeros into exactly the cycle in which that refusal is recorded. It then expects error bit 5 to be set and the older error bit 7 to be gone.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int unsigned FIELD_W = 8;
  localparam int unsigned DATA_W  = 3 * FIELD_W;
  localparam int unsigned ADDR_W  = 4;

  localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT     = 4'd1;
  localparam logic [ADDR_W-1:0] A_DLY_BASE = 4'd2;

  localparam int unsigned CTRL_EN_LSB   = 0;
  localparam int unsigned CTRL_MODE_LSB = FIELD_W;
  localparam int unsigned CTRL_B2B_LSB  = 2 * FIELD_W;
  localparam int unsigned STAT_ERR_LSB  = 0;
  localparam int unsigned STAT_FLAG_LSB = 2 * FIELD_W;
endpackage

// File: rtl/pt_cfg_regs.sv
module pt_cfg_regs
  import pt_pkg::*;
#(
  parameter int unsigned NUM_PT = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  output logic [NUM_PT-1:0]              en_o,
  output logic [NUM_PT-1:0]              mode_o,
  output logic [NUM_PT-1:0]              b2b_o,
  output logic [NUM_PT-1:0][CNT_W-1:0]   dly_o
);

  logic ctrl_we;
  logic [NUM_PT-1:0] en_q, mode_q, b2b_q;

  assign ctrl_we = wr_en_i && (wr_addr_i == A_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '0;
      b2b_q  <= '0;
    end else if (ctrl_we) begin
      en_q   <= wr_data_i[CTRL_EN_LSB   +: NUM_PT];
      mode_q <= wr_data_i[CTRL_MODE_LSB +: NUM_PT];
      b2b_q  <= wr_data_i[CTRL_B2B_LSB  +: NUM_PT];
    end
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign b2b_o  = b2b_q;

  // One delay register per slot, each at its own address
  for (genvar m = 0; m < NUM_PT; m++) begin : g_dly
    logic             dly_we;
    logic [CNT_W-1:0] dly_q;

    assign dly_we = wr_en_i && (wr_addr_i == ADDR_W'(int'(A_DLY_BASE) + m));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dly_q <= '0;
      else if (dly_we) dly_q <= wr_data_i[CNT_W-1:0];
    end

    assign dly_o[m] = dly_q;
  end

  // R11: a control write is visible in the next cycle
  a_r11_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (en_o == $past(wr_data_i[CTRL_EN_LSB +: NUM_PT])));

endmodule

// File: rtl/pt_trig_sched.sv
module pt_trig_sched #(
  parameter int unsigned NUM_PT = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned IDX_W  = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic [CNT_W-1:0]               count_i,
  input  logic [NUM_PT-1:0]              en_i,
  input  logic [NUM_PT-1:0]              mode_i,
  input  logic [NUM_PT-1:0]              b2b_i,
  input  logic [NUM_PT-1:0][CNT_W-1:0]   dly_i,
  input  logic [NUM_PT-1:0]              chain_go_i,
  input  logic                           flag_we_i,
  input  logic [NUM_PT-1:0]              flag_wdata_i,
  output logic                           fire_o,
  output logic [IDX_W-1:0]               sel_o,
  output logic [NUM_PT-1:0]              flag_o
);

  // Slot 0 has no lower neighbour, so its chain bit is masked off
  localparam logic [NUM_PT-1:0] CHAIN_OK = ~NUM_PT'(1);

  logic [NUM_PT-1:0] b2b_eff, chain_sel, dly_sel, imm_sel;
  logic [NUM_PT-1:0] match;
  logic [NUM_PT-1:0] dly_arm_q, dly_arm_n;
  logic [NUM_PT-1:0] chn_arm_q, chn_arm_n;
  logic [NUM_PT-1:0] dly_hit, chn_hit;
  logic [NUM_PT-1:0] new_req, cand, grant;
  logic [NUM_PT-1:0] pend_q, pend_n;
  logic [NUM_PT-1:0] flag_q, flag_n, flag_keep;
  logic              fire_q, fire_n;
  logic [IDX_W-1:0]  sel_q, sel_n;

  assign b2b_eff   = b2b_i & CHAIN_OK;
  assign chain_sel = en_i & b2b_eff;
  assign dly_sel   = en_i & mode_i & ~b2b_eff;
  assign imm_sel   = en_i & ~mode_i & ~b2b_eff;

  for (genvar m = 0; m < NUM_PT; m++) begin : g_cmp
    assign match[m] = (count_i == dly_i[m]);
  end

  // Arming and hit detection; a start re-arms and masks hits in its own cycle
  always_comb begin
    dly_hit = start_i ? '0 : (dly_arm_q & match);
    chn_hit = start_i ? '0 : (chn_arm_q & chain_go_i);
    if (start_i) begin
      dly_arm_n = dly_sel;
      chn_arm_n = chain_sel;
    end else begin
      dly_arm_n = dly_arm_q & ~dly_hit;
      chn_arm_n = chn_arm_q & ~chn_hit;
    end
  end

  // Request collection and lowest-index-first issue
  always_comb begin
    new_req = (start_i ? imm_sel : '0) | dly_hit | chn_hit;
    cand    = (pend_q | new_req) & en_i;
    grant   = cand & (~cand + NUM_PT'(1));
    pend_n  = cand & ~grant;
    fire_n  = |cand;
    sel_n   = sel_q;
    for (int i = 0; i < NUM_PT; i++) begin
      if (grant[i]) sel_n = IDX_W'(i);
    end
  end

  // Match flags: hardware set wins over a software clear
  always_comb begin
    flag_keep = flag_we_i ? flag_wdata_i : '1;
    flag_n    = start_i ? '0 : ((flag_q & flag_keep) | dly_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_arm_q <= '0;
      chn_arm_q <= '0;
      pend_q    <= '0;
      flag_q    <= '0;
      fire_q    <= 1'b0;
      sel_q     <= '0;
    end else begin
      dly_arm_q <= dly_arm_n;
      chn_arm_q <= chn_arm_n;
      pend_q    <= pend_n;
      flag_q    <= flag_n;
      fire_q    <= fire_n;
      if (fire_n) sel_q <= sel_n;
    end
  end

  assign fire_o = fire_q;
  assign sel_o  = sel_q;
  assign flag_o = flag_q;

  // R9: a start leaves every flag clear
  a_r9_start_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (flag_o == '0));

  // R2: an immediate slot with nothing queued fires in the next cycle
  a_r2_immediate_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (pend_q == '0) && (imm_sel != '0)) |=> fire_o);

endmodule

// File: rtl/pt_seq_mon.sv
module pt_seq_mon #(
  parameter int unsigned NUM_PT = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire_i,
  input  logic [IDX_W-1:0]   sel_i,
  input  logic               conv_busy_i,
  input  logic               conv_done_i,
  input  logic               err_we_i,
  input  logic [NUM_PT-1:0]  err_wdata_i,
  output logic [NUM_PT-1:0]  err_o,
  output logic [NUM_PT-1:0]  chain_go_o
);

  logic              own_act_q, own_act_n;
  logic [IDX_W-1:0]  owner_q;
  logic              busy_own, accept, refuse;
  logic [NUM_PT-1:0] err_q, err_n, err_set, err_keep;

  assign busy_own = own_act_q && conv_busy_i && !conv_done_i;
  assign accept   = fire_i && !busy_own;
  assign refuse   = fire_i && busy_own;

  always_comb begin
    if (accept)           own_act_n = 1'b1;
    else if (conv_done_i) own_act_n = 1'b0;
    else                  own_act_n = own_act_q;
  end

  always_comb begin
    err_set  = refuse ? (NUM_PT'(1) << sel_i) : '0;
    err_keep = err_we_i ? err_wdata_i : '1;
    err_n    = (err_q & err_keep) | err_set;
  end

  // Completion of a conversion owned by slot m-1 releases slot m
  assign chain_go_o[0] = 1'b0;
  for (genvar m = 1; m < NUM_PT; m++) begin : g_chain
    assign chain_go_o[m] = conv_done_i && own_act_q && (owner_q == IDX_W'(m - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_act_q <= 1'b0;
      owner_q   <= '0;
      err_q     <= '0;
    end else begin
      own_act_q <= own_act_n;
      if (accept) owner_q <= sel_i;
      err_q     <= err_n;
    end
  end

  assign err_o = err_q;

  // R7: a refused request marks its own slot
  a_r7_refused_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && own_act_q && conv_busy_i && !conv_done_i) |=> err_o[$past(sel_i)]);

  // R8: with no refusal, a status write masks the error bits
  a_r8_write_masks_err: assert property (@(posedge clk) disable iff (!rst_n)
    (err_we_i && !fire_i) |=> (err_o == ($past(err_o) & $past(err_wdata_i))));

endmodule

// File: rtl/pretrig_channel.sv
module pretrig_channel
  import pt_pkg::*;
#(
  parameter int unsigned NUM_PT = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    start_i,
  input  logic [CNT_W-1:0]                        count_i,
  input  logic                                    conv_busy_i,
  input  logic                                    conv_done_i,
  input  logic                                    wr_en_i,
  input  logic [ADDR_W-1:0]                       wr_addr_i,
  input  logic [DATA_W-1:0]                       wr_data_i,
  output logic                                    pt_fire_o,
  output logic [((NUM_PT > 1) ? $clog2(NUM_PT) : 1)-1:0] pt_sel_o,
  output logic [NUM_PT-1:0]                       err_o,
  output logic [NUM_PT-1:0]                       flag_o
);

  localparam int unsigned IDX_W = (NUM_PT > 1) ? $clog2(NUM_PT) : 1;

  logic [NUM_PT-1:0]            en, mode, b2b, chain_go;
  logic [NUM_PT-1:0][CNT_W-1:0] dly;
  logic                         stat_we;
  logic                         fire;
  logic [IDX_W-1:0]             sel;

  assign stat_we = wr_en_i && (wr_addr_i == A_STAT);

  pt_cfg_regs #(.NUM_PT(NUM_PT), .CNT_W(CNT_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .en_o      (en),
    .mode_o    (mode),
    .b2b_o     (b2b),
    .dly_o     (dly)
  );

  pt_trig_sched #(.NUM_PT(NUM_PT), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .count_i      (count_i),
    .en_i         (en),
    .mode_i       (mode),
    .b2b_i        (b2b),
    .dly_i        (dly),
    .chain_go_i   (chain_go),
    .flag_we_i    (stat_we),
    .flag_wdata_i (wr_data_i[STAT_FLAG_LSB +: NUM_PT]),
    .fire_o       (fire),
    .sel_o        (sel),
    .flag_o       (flag_o)
  );

  pt_seq_mon #(.NUM_PT(NUM_PT), .IDX_W(IDX_W)) u_mon (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire_i      (fire),
    .sel_i       (sel),
    .conv_busy_i (conv_busy_i),
    .conv_done_i (conv_done_i),
    .err_we_i    (stat_we),
    .err_wdata_i (wr_data_i[STAT_ERR_LSB +: NUM_PT]),
    .err_o       (err_o),
    .chain_go_o  (chain_go)
  );

  assign pt_fire_o = fire;
  assign pt_sel_o  = sel;

endmodule

// File: tb/test_pretrig_channel.sv
module test_pretrig_channel;

  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] cnt = '0;
  logic        busy = 1'b0;
  logic        done = 1'b0;
  int          left = 0;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [23:0] wr_data;
  logic        pt_fire_o;
  logic [2:0]  pt_sel_o;
  logic [7:0]  err_o, flag_o;

  int checks = 0;
  int errors = 0;
  int w_cnt;
  int w_off [4];
  int w_sel [4];

  // 50 MHz: 20 time-unit period, time unit taken as 1 ns
  always #10 clk = ~clk;

  pretrig_channel i_pretrig_channel (
    .clk(clk), .rst_n(rst_n), .start_i(start), .count_i(cnt),
    .conv_busy_i(busy), .conv_done_i(done),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .pt_fire_o(pt_fire_o), .pt_sel_o(pt_sel_o), .err_o(err_o), .flag_o(flag_o)
  );

  // Shared counter: restarts at 0 on a start
  always @(posedge clk) begin
    if (start) cnt <= '0;
    else       cnt <= cnt + 16'd1;
  end

  // Converter: takes a request when idle, busy LAT cycles, then a done pulse
  always @(posedge clk) begin
    done <= 1'b0;
    if (busy) begin
      if (left == 1) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        left <= left - 1;
      end
    end else if (pt_fire_o && rst_n) begin
      busy <= 1'b1;
      left <= LAT;
    end
  end

  typedef struct packed {
    logic [7:0]  en;
    logic [7:0]  mode;
    logic [15:0] dly;
    logic [2:0]  sel;
    logic [7:0]  off;   // 0 means no firing expected
    logic [7:0]  flag;
  } vec_t;

  // Offsets: immediate 1; delay d gives d+2 (counter reads 0 one cycle after start)
  localparam vec_t VECS [0:6] = '{
    '{8'h01, 8'h00, 16'd3,  3'd0, 8'd1,  8'h00},
    '{8'h08, 8'h08, 16'd3,  3'd3, 8'd5,  8'h08},
    '{8'h80, 8'h80, 16'd0,  3'd7, 8'd2,  8'h80},
    '{8'h00, 8'hFF, 16'd2,  3'd0, 8'd0,  8'h00},
    '{8'h10, 8'h00, 16'd9,  3'd4, 8'd1,  8'h00},
    '{8'h40, 8'h40, 16'd12, 3'd6, 8'd14, 8'h40},
    '{8'h20, 8'hDF, 16'd5,  3'd5, 8'd1,  8'h00}
  };

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Pulse start, then sample n cycles; offset 1 is the cycle after the start
  task automatic kick_watch(input int n);
    w_cnt = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= n; k++) begin
      if (k > 1) @(negedge clk);
      if (pt_fire_o) begin
        if (w_cnt < 4) begin
          w_off[w_cnt] = k;
          w_sel[w_cnt] = int'(pt_sel_o);
        end
        w_cnt++;
      end
    end
  endtask

  task automatic set_all_dly(input logic [15:0] d);
    for (int m = 0; m < 8; m++) wr(4'(2 + m), {8'h00, d});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fire after reset", 32'(pt_fire_o), 0);
    chk("R1 err after reset", 32'(err_o), 0);
    chk("R1 flag after reset", 32'(flag_o), 0);

    // Table: R2 immediate, R3 delay, R4 disabled, R9 flags cleared by start
    for (int v = 0; v < 7; v++) begin
      wr(4'd0, {8'h00, VECS[v].mode, VECS[v].en});
      set_all_dly(VECS[v].dly);
      kick_watch(20);
      chk($sformatf("R2/R3/R4 vector %0d fire count", v), 32'(w_cnt),
          (VECS[v].off == 0) ? 0 : 1);
      if (VECS[v].off != 0 && w_cnt > 0) begin
        chk($sformatf("R2/R3 vector %0d offset", v), 32'(w_off[0]), 32'(VECS[v].off));
        chk($sformatf("R2/R3 vector %0d select", v), 32'(w_sel[0]), 32'(VECS[v].sel));
      end
      chk($sformatf("R3/R9 vector %0d flags", v), 32'(flag_o), 32'(VECS[v].flag));
    end

    // R9: write 1 keeps a flag, write 0 clears it
    wr(4'd0, {8'h00, 8'h02, 8'h02});
    set_all_dly(16'd1);
    kick_watch(10);
    chk("R3 flag set for slot 1", 32'(flag_o), 32'h02);
    wr(4'd1, {8'hFF, 8'h00, 8'hFF});
    chk("R9 flag kept on write 1", 32'(flag_o), 32'h02);
    wr(4'd1, {8'hFD, 8'h00, 8'hFF});
    chk("R9 flag cleared on write 0", 32'(flag_o), 32'h00);

    // R5: slot 1 chained behind slot 0; delay 2 ignored; chain bit of slot 0 ignored
    wr(4'd0, {8'h03, 8'h00, 8'h03});
    set_all_dly(16'd2);
    kick_watch(14);
    chk("R5 chained fire count", 32'(w_cnt), 2);
    chk("R5 slot 0 offset", 32'(w_off[0]), 1);
    chk("R5 slot 0 select", 32'(w_sel[0]), 0);
    chk("R5 chained offset", 32'(w_off[1]), 32'(1 + 1 + LAT + 1));
    chk("R5 chained select", 32'(w_sel[1]), 1);
    chk("R7 no error when converter idle", 32'(err_o), 0);

    // R6 + R7: three immediate slots serialised, last two refused
    wr(4'd0, {8'h00, 8'h00, 8'hA4});
    kick_watch(12);
    chk("R6 fire count", 32'(w_cnt), 3);
    chk("R6 first select", 32'(w_sel[0]), 2);
    chk("R6 second select", 32'(w_sel[1]), 5);
    chk("R6 third select", 32'(w_sel[2]), 7);
    chk("R6 first offset", 32'(w_off[0]), 1);
    chk("R6 second offset", 32'(w_off[1]), 2);
    chk("R6 third offset", 32'(w_off[2]), 3);
    chk("R7 errors for refused slots", 32'(err_o), 32'hA0);

    // R8: bit 5 written 0 clears, bit 7 written 1 stays
    wr(4'd1, {8'hFF, 8'h00, 8'hDF});
    chk("R8 selective clear", 32'(err_o), 32'h80);

    // R10: slot 5 refused in the same cycle a clear-all write lands
    wr(4'd0, {8'h00, 8'h00, 8'h24});
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'd1; wr_data = {8'hFF, 8'h00, 8'h00};
    @(negedge clk); wr_en = 1'b0;
    chk("R10 set beats clear", 32'(err_o), 32'h20);
    repeat (10) @(negedge clk);

    // R1: reset while a delay slot is armed
    wr(4'd0, {8'h00, 8'h01, 8'h01});
    set_all_dly(16'd5);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 fire during reset", 32'(pt_fire_o), 0);
    chk("R1 err during reset", 32'(err_o), 0);
    rst_n = 1'b1;
    w_cnt = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (pt_fire_o) w_cnt++;
    end
    chk("R1 armed slot dropped by reset", 32'(w_cnt), 0);
    chk("R1 flags after reset", 32'(flag_o), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule